// File: doc/BRIEF.md
# Burst Address Sequencer

This block produces the address sequence for a four-beat burst into a synchronous, cache-style SRAM. A start address is taken from the address input whenever either of two active-low load strobes is low at a rising clock edge. One strobe serves the processor side and the other the cache-controller side, and they are treated alike. After a load, the lower two address bits move to the next beat on every edge where the active-low advance input is low. The upper bits keep their loaded value for the whole burst.

A mode input chooses the beat order. Low selects linear order, where the low bits count upward modulo four from the loaded value. High selects interleaved order, where the low bits are the loaded low bits XOR the beat number. An undriven mode pin is taken as high, so interleaved order is the default. Bursting is optional: a new address can be loaded on every cycle, with no idle cycles between loads. The outputs are the full current address and the index of the current beat.

Top module: `burst_addr_seq`

## Requirements
- R1: While the synchronous reset `rst` is high at a rising edge, the address output and the beat index both become zero.
- R2: When `ld_cpu_n` or `ld_ctl_n` (or both) is low at a rising edge, `addr_q` takes the value of `addr_d` and `beat_q` becomes 0 after that edge.
- R3: When both strobes are high and `adv_n` is low at a rising edge, `beat_q` increments by one modulo 4.
- R4: When both strobes and `adv_n` are high at a rising edge, `beat_q` and `addr_q` keep their values (with `order_sel` held constant).
- R5: When a strobe and `adv_n` are both low at the same edge, the load wins: `addr_q` equals `addr_d` and `beat_q` is 0.
- R6: With `order_sel` = 0 (linear), `addr_q[1:0]` equals (start low bits + `beat_q`) mod 4, giving for example 1,2,3,0 from a start of 1.
- R7: With `order_sel` = 1 (interleaved, the default), `addr_q[1:0]` equals start low bits XOR `beat_q`, giving for example 1,0,3,2 from a start of 1.
- R8: `addr_q[ADDR_W-1:2]` stays fixed between loads. After four advances the low bits return to the start value and nothing carries into the upper bits.
- R9: Loads on consecutive cycles each take effect at the next edge, so `addr_q` follows `addr_d` one cycle later with no bubble.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| ld_cpu_n | input | 1 | Processor-side load strobe, active low |
| ld_ctl_n | input | 1 | Controller-side load strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| order_sel | input | 1 | 0 = linear order, 1 = interleaved order (default) |
| addr_d | input | ADDR_W | External start address |
| addr_q | output | ADDR_W | Current burst address |
| beat_q | output | 2 | Current beat index, 0 to 3 |

## Verification
A load and an advance can be requested in the same cycle. The bench provokes this by driving a strobe low while `adv_n` is low, in the middle of a burst whose beat index is not zero. It passes only if the address returns to the new external value with beat 0, rather than stepping. The bench also drives both strobes low together, and it exercises wrap-around from a start of 3 with all upper bits set to one, so a carry into the upper bits would be visible.

// File: rtl/bas_pkg.sv
package bas_pkg;
  localparam int LOW_W = 2;
  typedef logic [LOW_W-1:0] beat_t;

  typedef enum logic {
    ORD_LINEAR     = 1'b0,
    ORD_INTERLEAVE = 1'b1
  } order_e;

  // Low address bits for beat k of a burst started at 'start'.
  function automatic beat_t beat_low(beat_t start, beat_t k, order_e ord);
    beat_t r;
    if (ord == ORD_INTERLEAVE) r = start ^ k;
    else                       r = beat_t'(start + k);
    return r;
  endfunction
endpackage

// File: rtl/bas_load_ctrl.sv
module bas_load_ctrl (
  input  logic ld_cpu_n,
  input  logic ld_ctl_n,
  input  logic adv_n,
  output logic load,
  output logic step
);
  // Either strobe loads; a load masks an advance in the same cycle.
  always_comb begin
    load = ~ld_cpu_n | ~ld_ctl_n;
    step = ~adv_n & ~load;
  end
endmodule

// File: rtl/bas_beat_ctr.sv
module bas_beat_ctr
  import bas_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  load,
  input  logic  step,
  output beat_t beat
);
  always_ff @(posedge clk) begin
    if (rst)       beat <= '0;
    else if (load) beat <= '0;
    else if (step) beat <= beat_t'(beat + 1'b1);
  end
endmodule

// File: rtl/bas_addr_reg.sv
module bas_addr_reg #(
  parameter int ADDR_W = 20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [ADDR_W-1:0] addr_d,
  output logic [ADDR_W-1:0] base
);
  always_ff @(posedge clk) begin
    if (rst)       base <= '0;
    else if (load) base <= addr_d;
  end
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
  import bas_pkg::*;
#(
  parameter int ADDR_W = 20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ld_cpu_n,
  input  logic              ld_ctl_n,
  input  logic              adv_n,
  input  logic              order_sel,
  input  logic [ADDR_W-1:0] addr_d,
  output logic [ADDR_W-1:0] addr_q,
  output logic [LOW_W-1:0]  beat_q
);
  localparam int HI_W = ADDR_W - LOW_W;

  // Named internal events, observed by the checker.
  logic              load_ev;
  logic              step_ev;
  logic [ADDR_W-1:0] base;
  beat_t             beat;
  order_e            ord;

  assign ord = order_e'(order_sel);

  bas_load_ctrl u_ctrl (
    .ld_cpu_n (ld_cpu_n),
    .ld_ctl_n (ld_ctl_n),
    .adv_n    (adv_n),
    .load     (load_ev),
    .step     (step_ev)
  );

  bas_beat_ctr u_beat (
    .clk  (clk),
    .rst  (rst),
    .load (load_ev),
    .step (step_ev),
    .beat (beat)
  );

  bas_addr_reg #(.ADDR_W(ADDR_W)) u_base (
    .clk    (clk),
    .rst    (rst),
    .load   (load_ev),
    .addr_d (addr_d),
    .base   (base)
  );

  generate
    if (HI_W > 0) begin : g_hi
      assign addr_q = {base[ADDR_W-1:LOW_W], beat_low(base[LOW_W-1:0], beat, ord)};
    end else begin : g_lo
      assign addr_q = beat_low(base[LOW_W-1:0], beat, ord);
    end
  endgenerate

  assign beat_q = beat;
endmodule

// File: rtl/burst_addr_seq_chk.sv
module burst_addr_seq_chk #(
  parameter int ADDR_W = 20
) (
  input logic              clk,
  input logic              rst,
  input logic              ld_cpu_n,
  input logic              ld_ctl_n,
  input logic              adv_n,
  input logic              order_sel,
  input logic [ADDR_W-1:0] addr_d,
  input logic [ADDR_W-1:0] addr_q,
  input logic [1:0]        beat_q,
  input logic              load_ev,
  input logic              step_ev
);
  logic strobe;
  assign strobe = ~ld_cpu_n | ~ld_ctl_n;

  a_r1_reset_clear: assert property (@(posedge clk)
    $past(rst) |-> (addr_q == '0 && beat_q == 2'd0));

  // R2 and R5: any strobe loads, whatever adv_n does
  a_r2_load: assert property (@(posedge clk) disable iff (rst)
    strobe |=> (addr_q == $past(addr_d) && beat_q == 2'd0));

  a_r5_load_wins: assert property (@(posedge clk) disable iff (rst)
    (strobe && !adv_n) |-> (load_ev && !step_ev));

  a_r3_step: assert property (@(posedge clk) disable iff (rst)
    (!strobe && !adv_n) |=> (beat_q == 2'($past(beat_q) + 2'd1)));

  a_r4_hold: assert property (@(posedge clk) disable iff (rst)
    (!strobe && adv_n) |=> $stable(beat_q));

  a_r6_linear: assert property (@(posedge clk) disable iff (rst)
    (!strobe && !adv_n && !order_sel) |=>
      (!order_sel |-> addr_q[1:0] == 2'($past(addr_q[1:0]) + 2'd1)));

  a_r7_interleave: assert property (@(posedge clk) disable iff (rst)
    (!strobe && !adv_n && order_sel) |=>
      (order_sel |-> (addr_q[1:0] ^ beat_q) == ($past(addr_q[1:0]) ^ $past(beat_q))));

  a_r8_upper_fixed: assert property (@(posedge clk) disable iff (rst)
    !strobe |=> $stable(addr_q[ADDR_W-1:2]));
endmodule

bind burst_addr_seq burst_addr_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .ld_cpu_n  (ld_cpu_n),
  .ld_ctl_n  (ld_ctl_n),
  .adv_n     (adv_n),
  .order_sel (order_sel),
  .addr_d    (addr_d),
  .addr_q    (addr_q),
  .beat_q    (beat_q),
  .load_ev   (load_ev),
  .step_ev   (step_ev)
);

// File: tb/test_burst_addr_seq.sv
module test_burst_addr_seq;
  localparam int AW = 20;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          ld_cpu_n = 1'b1;
  logic          ld_ctl_n = 1'b1;
  logic          adv_n = 1'b1;
  logic          order_sel = 1'b1;
  logic [AW-1:0] addr_d = '0;
  logic [AW-1:0] addr_q;
  logic [1:0]    beat_q;

  int n_checks = 0;
  int n_fails  = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  burst_addr_seq #(.ADDR_W(AW)) i_burst_addr_seq (
    .clk(clk), .rst(rst), .ld_cpu_n(ld_cpu_n), .ld_ctl_n(ld_ctl_n),
    .adv_n(adv_n), .order_sel(order_sel), .addr_d(addr_d),
    .addr_q(addr_q), .beat_q(beat_q)
  );

  task automatic check(string req, logic [AW-1:0] act, logic [AW-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Drive at the falling edge, let one rising edge pass, sample 1 ns later.
  task automatic cyc(logic cpu_n, logic ctl_n, logic a_n, logic [AW-1:0] a);
    @(negedge clk);
    ld_cpu_n = cpu_n; ld_ctl_n = ctl_n; adv_n = a_n; addr_d = a;
    @(posedge clk);
    #1;
  endtask

  function automatic logic [AW-1:0] expect_addr(logic [AW-1:0] s, int k, bit il);
    logic [AW-1:0] r;
    int lo;
    r = s;
    if (il) begin
      r[0] = s[0] ^ k[0];
      r[1] = s[1] ^ k[1];
    end else begin
      lo = (int'(s[1:0]) + k) % 4;
      r[1:0] = lo[1:0];
    end
    return r;
  endfunction

  task automatic t_reset();
    rst = 1'b1;
    cyc(1, 1, 1, '0);
    cyc(1, 1, 1, '0);
    check("R1 addr", addr_q, '0);
    check("R1 beat", AW'(beat_q), '0);
    @(negedge clk) rst = 1'b0;
  endtask

  task automatic t_load_each_strobe();
    cyc(0, 1, 1, 20'h12345);
    check("R2 cpu strobe addr", addr_q, 20'h12345);
    check("R2 cpu strobe beat", AW'(beat_q), '0);
    cyc(1, 0, 1, 20'hABCDE);
    check("R2 ctl strobe addr", addr_q, 20'hABCDE);
    cyc(0, 0, 1, 20'h00F0F);
    check("R2 both strobes addr", addr_q, 20'h00F0F);
  endtask

  task automatic t_burst(bit il, logic [AW-1:0] s);
    @(negedge clk) order_sel = il;
    cyc(0, 1, 1, s);
    check(il ? "R7 beat0" : "R6 beat0", addr_q, s);
    for (int k = 1; k <= 4; k++) begin
      cyc(1, 1, 0, '0);
      check(il ? "R7 interleaved addr" : "R6 linear addr", addr_q, expect_addr(s, k % 4, il));
      check("R3 beat index", AW'(beat_q), AW'(k % 4));
    end
    // back at start after four advances: no carry into upper bits
    check("R8 wrap/upper bits", addr_q, s);
  endtask

  task automatic t_hold();
    @(negedge clk) order_sel = 1'b0;
    cyc(1, 0, 1, 20'h55551);
    cyc(1, 1, 0, '0);
    cyc(1, 1, 1, 20'hFFFFF);
    cyc(1, 1, 1, 20'h00000);
    check("R4 hold addr", addr_q, 20'h55552);
    check("R4 hold beat", AW'(beat_q), 20'd1);
  endtask

  task automatic t_priority();
    @(negedge clk) order_sel = 1'b1;
    cyc(0, 1, 1, 20'h33330);
    cyc(1, 1, 0, '0);
    cyc(1, 1, 0, '0);
    check("R5 mid burst beat", AW'(beat_q), 20'd2);
    cyc(1, 0, 0, 20'h77773);
    check("R5 load over advance addr", addr_q, 20'h77773);
    check("R5 load over advance beat", AW'(beat_q), '0);
    cyc(0, 0, 0, 20'h11112);
    check("R5 both strobes with advance", addr_q, 20'h11112);
  endtask

  task automatic t_back_to_back();
    for (int i = 0; i < 6; i++) begin
      logic [AW-1:0] a;
      a = AW'(32'h0A5A0 + i * 32'h01111);
      cyc(i[0], ~i[0], i[1], a);
      check("R9 back-to-back load", addr_q, a);
    end
  endtask

  initial begin
    t_reset();
    t_load_each_strobe();
    t_burst(1'b0, 20'h00001);
    t_burst(1'b1, 20'h00001);
    t_burst(1'b0, 20'hFFFFF);
    t_burst(1'b1, 20'hFFFFE);
    t_hold();
    t_priority();
    t_back_to_back();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end
endmodule